// File: doc/BRIEF.md
# Debug Port Target Register Set

This block is the target end of a scan-based debug port for a processor core. A standard test access port state machine outside the block hands it capture, shift and update strobes for both the instruction path and the data path, together with the serial input. The block drives the serial output. A 5-bit instruction register chooses which data register lies between serial input and serial output. The choices are a device identity word, an implementation word, an address register, a data register, a 32-bit control register, a 96-bit chain of all three, a 33-bit fast-data path, or a one-bit bypass stage.

On the processor side the block offers a request/acknowledge channel for loads and stores that the debug probe serves. A request latches its address, direction and size, and, for a store, its write data. The request raises the pending-access flag in the control register. The probe inspects the access, supplies load data through the data register, and ends the access by writing the pending flag to zero. The fast-data path combines both steps in one scan. The control register also carries a reset-occurred flag, a core reset request, a probe-enable gate, a debug interrupt request and the core's debug-mode status.

All register contents change only on an update strobe or on a processor event. A capture strobe copies the selected register into the shift stage. Bits leave least significant first.

Top module: `dbgport_regs`

## Requirements
- R1: After reset the instruction register selects the identity word, pAck, coreRstReq and dbgIntReq are 0, and the control register reads 32'h8000_0000.
- R2: Instruction capture loads 5'b00001, shifted out LSB first. Codes select: 0x01 identity (32 bits), 0x03 implementation (32), 0x08 address (32), 0x09 data (32), 0x0A control (32), 0x0B chain (96), 0x0E fast data (33).
- R3: Every other instruction code selects a one-stage bypass that captures 0, so shifted data reappears one bit later.
- R4: A data scan captures the selected register on capture, shifts LSB first, and alters register contents only on the update strobe.
- R5: A processor request is accepted only while control bit 15 (probe enable) is 1. Acceptance sets bit 18 (pending) and bit 19 (1 = store), and places the size in bits 30:29 (0 byte, 1 halfword, 2 word, 3 triple). It also makes the address readable in the address register.
- R6: Writing control bit 18 as 0 while an access is pending clears it and gives a one-cycle pAck. Writing 1 leaves it pending with no pAck. Writing 0 with nothing pending gives no pAck.
- R7: An update of the data register sets pRdata. An accepted store loads pWdata into the data register.
- R8: Control bit 31 reads 1 after reset. Writing 0 clears it, and writing 1 has no effect.
- R9: Control bit 16 drives coreRstReq. Writing 1 to bit 12 raises dbgIntReq, which clears once inDebug is 1. Bit 3 reads inDebug.
- R10: The fast-data register holds a completion bit at bit 0, shifted first, followed by 32 data bits. It captures 1 while an access is pending. Shifting in 0 while pending completes the access with pAck, and for a load the data field is written to the data register. Shifting in 1, or any scan with nothing pending, changes nothing.
- R11: The chain register shifts control bits first, then data, then address. An update writes control and data.
- R12: The address register is read-only from the scan side, so an update leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Active-low reset |
| capIr | input | 1 | Instruction capture strobe |
| shiftIr | input | 1 | Instruction shift strobe |
| updIr | input | 1 | Instruction update strobe |
| capDr | input | 1 | Data capture strobe |
| shiftDr | input | 1 | Data shift strobe |
| updDr | input | 1 | Data update strobe |
| tdi | input | 1 | Serial input |
| tdo | output | 1 | Serial output |
| pReq | input | 1 | Processor access request |
| pWrite | input | 1 | 1 = store, 0 = load |
| pSize | input | 2 | Access size code |
| pAddr | input | 32 | Access address |
| pWdata | input | 32 | Store data |
| pAck | output | 1 | One-cycle completion pulse |
| pRdata | output | 32 | Load data (data register) |
| inDebug | input | 1 | Core is in debug mode |
| coreRstReq | output | 1 | Core reset request |
| dbgIntReq | output | 1 | Debug interrupt request |

## Verification
The hardest states to reach are those in which an access is pending, because each one needs the probe-enable bit set by a control write, a processor request, and then the correct scan sequence. The bench performs these steps in directed order. It then checks that the pending flag survives a write of 1 and a fast-data scan with the completion bit at 1. Only after that does it complete the access, once through the control register and once through the fast-data path, for both a store and a load. Random instruction codes and random data words cover the bypass and data paths around these sequences.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;

  localparam int IR_W   = 5;
  localparam int WORD_W = 32;

  localparam logic [IR_W-1:0] OP_IDENT = 5'h01;
  localparam logic [IR_W-1:0] OP_IMPL  = 5'h03;
  localparam logic [IR_W-1:0] OP_ADDR  = 5'h08;
  localparam logic [IR_W-1:0] OP_DATA  = 5'h09;
  localparam logic [IR_W-1:0] OP_CTRL  = 5'h0A;
  localparam logic [IR_W-1:0] OP_CHAIN = 5'h0B;
  localparam logic [IR_W-1:0] OP_FAST  = 5'h0E;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  // Control word bit positions (probe software decodes these)
  localparam int CB_ROCC   = 31;
  localparam int CB_SZ_HI  = 30;
  localparam int CB_SZ_LO  = 29;
  localparam int CB_PRNW   = 19;
  localparam int CB_PEND   = 18;
  localparam int CB_CRST   = 16;
  localparam int CB_PROBEN = 15;
  localparam int CB_BRK    = 12;
  localparam int CB_DM     = 3;

  typedef enum logic [2:0] {
    SEL_BYPASS, SEL_IDENT, SEL_IMPL, SEL_ADDR,
    SEL_DATA, SEL_CTRL, SEL_CHAIN, SEL_FAST
  } regSelT;

  typedef struct packed {
    logic   capture;
    logic   shift;
    logic   update;
    regSelT sel;
  } drStrobeT;

  function automatic int selLen(regSelT s, int w);
    case (s)
      SEL_BYPASS: return 1;
      SEL_CHAIN:  return 3 * w;
      SEL_FAST:   return w + 1;
      default:    return w;
    endcase
  endfunction

endpackage

// File: rtl/dbgport_ctl.sv
module dbgport_ctl
  import dbgport_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     capIr,
  input  logic     shiftIr,
  input  logic     updIr,
  input  logic     capDr,
  input  logic     shiftDr,
  input  logic     updDr,
  input  logic     tdi,
  output logic     irTdo,
  output drStrobeT strobe
);

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;
  regSelT          selNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irShift <= '0;
      irReg   <= OP_IDENT;
    end else begin
      if (capIr)        irShift <= IR_CAPTURE;
      else if (shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (updIr)        irReg   <= irShift;
    end
  end

  always_comb begin
    case (irReg)
      OP_IDENT: selNow = SEL_IDENT;
      OP_IMPL:  selNow = SEL_IMPL;
      OP_ADDR:  selNow = SEL_ADDR;
      OP_DATA:  selNow = SEL_DATA;
      OP_CTRL:  selNow = SEL_CTRL;
      OP_CHAIN: selNow = SEL_CHAIN;
      OP_FAST:  selNow = SEL_FAST;
      default:  selNow = SEL_BYPASS;
    endcase
  end

  assign irTdo          = irShift[0];
  assign strobe.capture = capDr;
  assign strobe.shift   = shiftDr;
  assign strobe.update  = updDr;
  assign strobe.sel     = selNow;

endmodule

// File: rtl/dbgport_path.sv
module dbgport_path
  import dbgport_pkg::*;
#(
  parameter int                WIDTH     = WORD_W,
  parameter logic [WIDTH-1:0]  IDENT_VAL = 32'h1234_5001,
  parameter logic [WIDTH-1:0]  IMPL_VAL  = 32'h0000_4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  drStrobeT         strobe,
  input  logic             tdi,
  output logic             drTdo,
  input  logic             pReq,
  input  logic             pWrite,
  input  logic [1:0]       pSize,
  input  logic [WIDTH-1:0] pAddr,
  input  logic [WIDTH-1:0] pWdata,
  output logic             pAck,
  output logic [WIDTH-1:0] pRdata,
  input  logic             inDebug,
  output logic             coreRstReq,
  output logic             dbgIntReq
);

  localparam int SH_W  = 3 * WIDTH;
  localparam int LEN_W = $clog2(SH_W);

  logic [SH_W-1:0]  shReg, shNext, capVal;
  logic [LEN_W-1:0] lenM1;

  logic             rocc, pend, prnw, probEn, crst, brk, ackQ;
  logic [1:0]       psz;
  logic [WIDTH-1:0] addrReg, dataReg, ctrlRead, ctrlIn, dataIn;

  logic isCtrlWr, isDataWr, accept, complete;

  // Control word as seen by the probe
  always_comb begin
    ctrlRead                    = '0;
    ctrlRead[CB_ROCC]           = rocc;
    ctrlRead[CB_SZ_HI:CB_SZ_LO] = psz;
    ctrlRead[CB_PRNW]           = prnw;
    ctrlRead[CB_PEND]           = pend;
    ctrlRead[CB_CRST]           = crst;
    ctrlRead[CB_PROBEN]         = probEn;
    ctrlRead[CB_BRK]            = brk;
    ctrlRead[CB_DM]             = inDebug;
  end

  always_comb begin
    capVal = '0;
    case (strobe.sel)
      SEL_IDENT: capVal[WIDTH-1:0] = IDENT_VAL;
      SEL_IMPL:  capVal[WIDTH-1:0] = IMPL_VAL;
      SEL_ADDR:  capVal[WIDTH-1:0] = addrReg;
      SEL_DATA:  capVal[WIDTH-1:0] = dataReg;
      SEL_CTRL:  capVal[WIDTH-1:0] = ctrlRead;
      SEL_CHAIN: capVal            = {addrReg, dataReg, ctrlRead};
      SEL_FAST:  capVal[WIDTH:0]   = {dataReg, pend};
      default:   capVal            = '0;
    endcase
  end

  assign lenM1 = LEN_W'(selLen(strobe.sel, WIDTH) - 1);

  always_comb begin
    shNext        = {1'b0, shReg[SH_W-1:1]};
    shNext[lenM1] = tdi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shReg <= '0;
    else if (strobe.capture) shReg <= capVal;
    else if (strobe.shift)   shReg <= shNext;
  end

  assign drTdo = shReg[0];

  // Field extraction from the shift stage at update time
  always_comb begin
    ctrlIn = shReg[WIDTH-1:0];
    dataIn = shReg[WIDTH-1:0];
    case (strobe.sel)
      SEL_CHAIN: dataIn = shReg[2*WIDTH-1:WIDTH];
      SEL_FAST:  dataIn = shReg[WIDTH:1];
      default:   dataIn = shReg[WIDTH-1:0];
    endcase
  end

  assign isCtrlWr = strobe.update &&
                    (strobe.sel == SEL_CTRL || strobe.sel == SEL_CHAIN);
  assign complete = pend && ((isCtrlWr && !ctrlIn[CB_PEND]) ||
                    (strobe.update && strobe.sel == SEL_FAST && !shReg[0]));
  assign isDataWr = strobe.update &&
                    ((strobe.sel == SEL_DATA) || (strobe.sel == SEL_CHAIN) ||
                     (strobe.sel == SEL_FAST && complete && !prnw));
  assign accept   = pReq && probEn && !pend && !ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rocc    <= 1'b1;
      pend    <= 1'b0;
      prnw    <= 1'b0;
      psz     <= 2'd0;
      probEn  <= 1'b0;
      crst    <= 1'b0;
      brk     <= 1'b0;
      ackQ    <= 1'b0;
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      ackQ <= complete;
      if (complete) begin
        pend <= 1'b0;
      end else if (accept) begin
        pend    <= 1'b1;
        prnw    <= pWrite;
        psz     <= pSize;
        addrReg <= pAddr;
      end
      if (accept && pWrite) dataReg <= pWdata;
      else if (isDataWr)    dataReg <= dataIn;
      if (isCtrlWr) begin
        if (!ctrlIn[CB_ROCC]) rocc <= 1'b0;
        crst   <= ctrlIn[CB_CRST];
        probEn <= ctrlIn[CB_PROBEN];
      end
      if (inDebug)                        brk <= 1'b0;
      else if (isCtrlWr && ctrlIn[CB_BRK]) brk <= 1'b1;
    end
  end

  assign pAck       = ackQ;
  assign pRdata     = dataReg;
  assign coreRstReq = crst;
  assign dbgIntReq  = brk;

endmodule

// File: rtl/dbgport_regs.sv
module dbgport_regs
  import dbgport_pkg::*;
#(
  parameter logic [WORD_W-1:0] IDENT_VAL = 32'h1234_5001,
  parameter logic [WORD_W-1:0] IMPL_VAL  = 32'h0000_4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capIr,
  input  logic              shiftIr,
  input  logic              updIr,
  input  logic              capDr,
  input  logic              shiftDr,
  input  logic              updDr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              pReq,
  input  logic              pWrite,
  input  logic [1:0]        pSize,
  input  logic [WORD_W-1:0] pAddr,
  input  logic [WORD_W-1:0] pWdata,
  output logic              pAck,
  output logic [WORD_W-1:0] pRdata,
  input  logic              inDebug,
  output logic              coreRstReq,
  output logic              dbgIntReq
);

  drStrobeT strobe;
  logic     irTdo, drTdo;

  dbgport_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .capIr(capIr), .shiftIr(shiftIr), .updIr(updIr),
    .capDr(capDr), .shiftDr(shiftDr), .updDr(updDr),
    .tdi(tdi), .irTdo(irTdo), .strobe(strobe)
  );

  dbgport_path #(.WIDTH(WORD_W), .IDENT_VAL(IDENT_VAL), .IMPL_VAL(IMPL_VAL)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tdi(tdi), .drTdo(drTdo),
    .pReq(pReq), .pWrite(pWrite), .pSize(pSize), .pAddr(pAddr),
    .pWdata(pWdata), .pAck(pAck), .pRdata(pRdata),
    .inDebug(inDebug), .coreRstReq(coreRstReq), .dbgIntReq(dbgIntReq)
  );

  assign tdo = shiftIr ? irTdo : drTdo;

endmodule

// File: rtl/dbgport_regs_chk.sv
module dbgport_regs_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         updDr,
  input logic         pReq,
  input logic         pAck,
  input logic [W-1:0] pRdata,
  input logic         inDebug,
  input logic         coreRstReq,
  input logic         dbgIntReq
);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    pAck |=> !pAck);

  p_ack_from_update_r6: assert property (@(posedge clk) disable iff (!rstN)
    pAck |-> $past(updDr));

  p_rdata_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pRdata) |-> ($past(updDr) || $past(pReq)));

  p_crst_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(coreRstReq) |-> $past(updDr));

  p_brk_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    inDebug |=> !dbgIntReq);

endmodule

bind dbgport_regs dbgport_regs_chk #(.W(32)) u_chk (
  .clk(clk), .rstN(rstN), .updDr(updDr), .pReq(pReq), .pAck(pAck),
  .pRdata(pRdata), .inDebug(inDebug), .coreRstReq(coreRstReq),
  .dbgIntReq(dbgIntReq)
);

// File: tb/dbgport_regs_tb.sv
`timescale 1ns/1ps
module dbgport_regs_tb;

  localparam logic [31:0] IDV = 32'h1234_5001;
  localparam logic [31:0] IMV = 32'h0000_4000;

  logic clk = 0, rstN = 0;
  logic capIr = 0, shiftIr = 0, updIr = 0, capDr = 0, shiftDr = 0, updDr = 0, tdi = 0;
  logic tdo, pReq = 0, pWrite = 0, pAck, inDebug = 0, coreRstReq, dbgIntReq;
  logic [1:0]  pSize = 0;
  logic [31:0] pAddr = 0, pWdata = 0, pRdata;

  int checks = 0, failures = 0, ackCnt = 0;
  logic [31:0] dataModel = 0;

  always #4 clk = ~clk;

  dbgport_regs #(.IDENT_VAL(IDV), .IMPL_VAL(IMV)) u_dut (.*);

  always @(posedge clk) if (rstN && pAck) ackCnt++;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic irScan(input logic [4:0] code, output logic [4:0] cap);
    @(negedge clk) capIr = 1;
    @(negedge clk) capIr = 0;
    for (int i = 0; i < 5; i++) begin
      tdi = code[i]; shiftIr = 1; #1 cap[i] = tdo;
      @(negedge clk);
    end
    shiftIr = 0; updIr = 1;
    @(negedge clk) updIr = 0;
  endtask

  task automatic drScan(input int w, input logic [127:0] din, output logic [127:0] dout);
    dout = '0;
    @(negedge clk) capDr = 1;
    @(negedge clk) capDr = 0;
    for (int i = 0; i < w; i++) begin
      tdi = din[i]; shiftDr = 1; #1 dout[i] = tdo;
      @(negedge clk);
    end
    shiftDr = 0; updDr = 1;
    @(negedge clk) updDr = 0;
    @(negedge clk);
  endtask

  // expected serial output for a register of length len with captured value cap
  function automatic logic [127:0] expScan(int len, int w, logic [127:0] cap, logic [127:0] din);
    logic [127:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = (i < len) ? cap[i] : din[i-len];
    return r;
  endfunction

  function automatic logic [31:0] mkCtrl(logic rocc, logic [1:0] sz, logic nw, logic pend,
                                         logic crst, logic pe, logic brk, logic dm);
    logic [31:0] c = '0;
    c[31] = rocc; c[30:29] = sz; c[19] = nw; c[18] = pend;
    c[16] = crst; c[15] = pe; c[12] = brk; c[3] = dm;
    return c;
  endfunction

  task automatic scanReg(input logic [4:0] code, input int w, input logic [127:0] din,
                         output logic [127:0] dout);
    logic [4:0] ic;
    irScan(code, ic);
    drScan(w, din, dout);
  endtask

  task automatic request(input logic wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk) pReq = 1; pWrite = wr; pSize = sz; pAddr = a; pWdata = d;
    @(negedge clk) pReq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] o, din;
    logic [4:0] ic;
    int a0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pAck", pAck, 0);
    chk("R1 coreRstReq", coreRstReq, 0);
    chk("R1 dbgIntReq", dbgIntReq, 0);
    din = 128'hA5;
    drScan(40, din, o);
    chk("R1 ident selected", o, expScan(32, 40, IDV, din));

    // R2 instruction capture and decode
    irScan(5'h03, ic);
    chk("R2 ir capture", ic, 5'b00001);
    din = {$urandom, $urandom};
    drScan(40, din, o);
    chk("R2 impl length", o, expScan(32, 40, IMV, din));
    scanReg(5'h0A, 32, mkCtrl(1,0,0,1,0,0,0,0), o);
    chk("R1 control reset value", o[31:0], 32'h8000_0000);

    // R3/R4/R7 random codes
    for (int n = 0; n < 40; n++) begin
      logic [4:0] code;
      code = 5'($urandom);
      if (code == 5'h08 || code == 5'h0A || code == 5'h0B || code == 5'h0E) code = 5'h1F;
      din = {$urandom, $urandom};
      scanReg(code, 40, din, o);
      case (code)
        5'h01: chk("R2 ident", o, expScan(32, 40, IDV, din));
        5'h03: chk("R2 impl", o, expScan(32, 40, IMV, din));
        5'h09: begin
          chk("R4 data capture", o, expScan(32, 40, dataModel, din));
          dataModel = din[39:8];
          chk("R7 pRdata after update", pRdata, dataModel);
        end
        default: chk("R3 bypass", o, expScan(1, 40, 0, din));
      endcase
    end

    // R8 reset-occurred flag
    scanReg(5'h0A, 32, mkCtrl(1,0,0,1,0,0,0,0), o);
    scanReg(5'h0A, 32, mkCtrl(0,0,0,1,0,0,0,0), o);
    chk("R8 rocc still set after writing 1", o[31], 1);
    scanReg(5'h0A, 32, mkCtrl(1,0,0,1,0,0,0,0), o);
    chk("R8 rocc cleared", o[31], 0);
    scanReg(5'h0A, 32, mkCtrl(1,0,0,1,0,0,0,0), o);
    chk("R8 rocc write 1 no effect", o[31], 0);

    // R5 request gated by probe enable
    request(0, 2'd2, 32'h0000_1000, 0);
    scanReg(5'h0A, 32, mkCtrl(0,0,0,1,0,1,0,0), o);
    chk("R5 no accept when disabled", o[31:0], 32'h0);
    request(0, 2'd2, 32'hBFC0_0200, 0);
    scanReg(5'h0A, 32, mkCtrl(0,0,0,1,0,1,0,0), o);
    chk("R5 load pending", o[31:0], mkCtrl(0,2'd2,0,1,0,1,0,0));
    din = {96'h0, $urandom};
    scanReg(5'h08, 32, din, o);
    chk("R5 address visible", o[31:0], 32'hBFC0_0200);
    scanReg(5'h08, 32, 0, o);
    chk("R12 address ignores update", o[31:0], 32'hBFC0_0200);

    // R6 handshake via control
    a0 = ackCnt;
    scanReg(5'h0A, 32, mkCtrl(0,0,0,1,0,1,0,0), o);
    chk("R6 write 1 keeps pending", ackCnt - a0, 0);
    scanReg(5'h09, 32, 32'hCAFE_0123, o);
    scanReg(5'h0A, 32, mkCtrl(0,0,0,0,0,1,0,0), o);
    chk("R6 still pending before finish", o[18], 1);
    @(negedge clk);
    chk("R6 one ack", ackCnt - a0, 1);
    chk("R7 load data", pRdata, 32'hCAFE_0123);
    dataModel = 32'hCAFE_0123;
    scanReg(5'h0A, 32, mkCtrl(0,0,0,0,0,1,0,0), o);
    chk("R6 pending cleared", o[18], 0);
    @(negedge clk);
    chk("R6 no ack when idle", ackCnt - a0, 1);

    // R10 fast data, store
    request(1, 2'd1, 32'h8000_0040, 32'h1357_9BDF);
    chk("R7 store data loaded", pRdata, 32'h1357_9BDF);
    scanReg(5'h0E, 33, {95'h0, 1'b1}, o);
    chk("R10 capture pending store", o[32:0], {32'h1357_9BDF, 1'b1});
    @(negedge clk);
    chk("R10 spracc 1 no completion", ackCnt - a0, 1);
    scanReg(5'h0E, 33, {32'hFFFF_0000, 1'b0}, o);
    @(negedge clk);
    chk("R10 store completes", ackCnt - a0, 2);
    chk("R10 store data unchanged", pRdata, 32'h1357_9BDF);

    // R10 fast data, load
    request(0, 2'd0, 32'h8000_0044, 0);
    scanReg(5'h0E, 33, {32'h2468_ACE0, 1'b0}, o);
    @(negedge clk);
    chk("R10 load completes", ackCnt - a0, 3);
    chk("R10 load data written", pRdata, 32'h2468_ACE0);
    scanReg(5'h0E, 33, {32'h0BAD_0BAD, 1'b0}, o);
    chk("R10 idle captures 0", o[0], 0);
    @(negedge clk);
    chk("R10 idle no ack", ackCnt - a0, 3);
    chk("R10 idle data ignored", pRdata, 32'h2468_ACE0);

    // R11 chain order
    din = {32'h0, 32'h7777_1111, mkCtrl(0,0,0,1,0,1,0,0)};
    scanReg(5'h0B, 96, din, o);
    chk("R11 chain capture", o[95:0], {32'h8000_0044, 32'h2468_ACE0, mkCtrl(0,0,0,0,0,1,0,0)});
    chk("R11 chain data written", pRdata, 32'h7777_1111);

    // R9 control outputs
    scanReg(5'h0A, 32, mkCtrl(0,0,0,1,1,1,1,0), o);
    chk("R9 core reset request", coreRstReq, 1);
    chk("R9 debug interrupt", dbgIntReq, 1);
    @(negedge clk) inDebug = 1;
    @(negedge clk);
    chk("R9 interrupt cleared in debug", dbgIntReq, 0);
    scanReg(5'h0A, 32, mkCtrl(0,0,0,1,0,1,0,0), o);
    chk("R9 debug mode bit", o[3], 1);
    chk("R9 reset request dropped", coreRstReq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule